// File: doc/BRIEF.md
# Interleaved Multi-Phase PWM Generator

This block drives the gates of a six-leg synchronous boost stage. A master counter runs without stopping and sets the switching period. As it passes a set of evenly spaced compare points, it restarts a one-shot counter in each leg. Each leg's counter then times that leg's duty cycle. Because the phase offset comes from the master compare points and the duty comes from each leg's own register, the two are set independently of each other.

Each leg produces a complementary pair of gate signals: a high-side drive and a low-side drive. A programmable gap is inserted on both edges, so that one switch turns off before the other turns on. Each leg also emits a one-cycle pulse in the middle of its off interval, which is used to start a current sample.

A mask can switch legs off while the stage runs, to shed phases at light load. A second per-leg flag keeps the high-side switch off so that the leg runs non-synchronously. A fault input blanks every gate at once, and the block holds that state until it is cleared explicitly.

Top module: `ilv_pwm`

## Requirements
- R1: The master count runs 0,1,...,P and then returns to 0, where P is the active period. One period therefore lasts P+1 clock cycles. The `period` input is copied into the active period only in the cycle in which the count equals the active period (the wrap cycle).
- R2: Leg i, for i = 0..NPH-1, is restarted when the master count equals floor((P+1)*i/NPH). Its counter then counts 0..P once and stops, unless it is restarted first.
- R3: A leg's raw on-state is true while its counter is below that leg's duty value. Duty words sit in `duty[i*CW +: CW]`. They are copied into the active set at the master wrap and are applied to a leg when that leg is next restarted.
- R4: `gate_hi[i]` follows the raw on-state, delayed by one register, and rises only after the delayed state has held high for `dead` further cycles. `gate_lo[i]` follows the delayed off-state with the same gap. The two outputs of a leg are never high together.
- R5: `adc_trig[i]` pulses for one cycle when the leg's counter equals D + floor((P+1-D)/2), where D is the leg's duty. No pulse is produced when D > P.
- R6: A leg whose `phase_en` bit is 0 holds both gates low and produces no trigger. The bit is taken in at the master wrap and applied at the leg's restart.
- R7: A leg whose `nonsync` bit is 1 holds `gate_hi` low while `gate_lo` keeps switching. The bit follows the same timing as the mask.
- R8: While `fault_in` is high, all gate outputs are low in the same cycle, with no clock edge needed.
- R9: After `fault_in` has been high, the gates stay low until `fault_clr` is high at a clock edge while `fault_in` is low.
- R10: During reset all gates and triggers are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period | input | CW | Period value P (one period lasts P+1 cycles) |
| duty | input | NPH*CW | Duty word for each leg |
| dead | input | DTW | Gap length, in cycles, on each edge |
| phase_en | input | NPH | Mask of enabled legs |
| nonsync | input | NPH | Flags for legs driven on the low side only |
| fault_in | input | 1 | Asynchronous fault, active high |
| fault_clr | input | 1 | Clears the latched fault |
| gate_hi | output | NPH | High-side gate drives |
| gate_lo | output | NPH | Low-side gate drives |
| adc_trig | output | NPH | Mid-off-time sample pulses |

## Verification
The gate outputs trail the leg counter comparison by one register. On top of that comes the dead-time count. A new duty, mask or flag shows only after the next master wrap and then the leg's own restart. The fault response is combinational and is checked about 1 ns after `fault_in` is driven, inside the same cycle. A cycle model in the bench advances on every rising edge. The outputs are compared with it on every falling edge, so each of these delays is counted exactly. Further directed windows measure the trigger spacing, the phase offsets and the on-times over one whole period.

// File: rtl/ilv_pwm.sv
module ilv_pwm #(
  parameter int NPH = 6,
  parameter int CW  = 16,
  parameter int DTW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     period,
  input  logic [NPH*CW-1:0] duty,
  input  logic [DTW-1:0]    dead,
  input  logic [NPH-1:0]    phase_en,
  input  logic [NPH-1:0]    nonsync,
  input  logic              fault_in,
  input  logic              fault_clr,
  output logic [NPH-1:0]    gate_hi,
  output logic [NPH-1:0]    gate_lo,
  output logic [NPH-1:0]    adc_trig
);
  localparam int OW = CW + 4;

  logic [CW-1:0]     mcnt, per_a;
  logic [NPH*CW-1:0] duty_a;
  logic [NPH-1:0]    en_a, ns_a;
  logic              fault_q, flt, wrap;

  assign wrap = (mcnt == per_a);
  assign flt  = fault_q | fault_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt <= '0; per_a <= '0; duty_a <= '0; en_a <= '0; ns_a <= '0;
    end else if (wrap) begin
      mcnt <= '0; per_a <= period; duty_a <= duty; en_a <= phase_en; ns_a <= nonsync;
    end else begin
      mcnt <= mcnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n or posedge fault_in) begin
    if (!rst_n)         fault_q <= 1'b0;
    else if (fault_in)  fault_q <= 1'b1;
    else if (fault_clr) fault_q <= 1'b0;
  end

  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n) wrap |=> (mcnt == '0));
  a_r8_fault_blank: assert property (@(posedge clk) disable iff (!rst_n) flt |-> (gate_hi == '0 && gate_lo == '0));
  a_r9_fault_held: assert property (@(posedge clk) disable iff (!rst_n) (fault_q && !fault_clr) |=> fault_q);

  for (genvar g = 0; g < NPH; g++) begin : g_leg
    logic [OW-1:0]  off;
    logic           trig, run, en_p, ns_p, raw, pq, mid_ok;
    logic [CW-1:0]  sc, dp;
    logic [DTW-1:0] dc;
    logic [CW:0]    mid;

    assign off  = ((OW'(per_a) + OW'(1)) * OW'(g)) / OW'(NPH);
    assign trig = (OW'(mcnt) == off);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sc <= '0; dp <= '0; run <= 1'b0; en_p <= 1'b0; ns_p <= 1'b0;
      end else if (trig) begin
        sc <= '0; run <= 1'b1;
        dp <= duty_a[g*CW +: CW]; en_p <= en_a[g]; ns_p <= ns_a[g];
      end else if (run) begin
        if (sc == per_a) run <= 1'b0;
        else             sc  <= sc + CW'(1);
      end
    end

    assign raw = run & en_p & (sc < dp);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pq <= 1'b0; dc <= '0;
      end else begin
        pq <= raw;
        if (raw != pq)          dc <= '0;
        else if (dc != '1)      dc <= dc + DTW'(1);
      end
    end

    assign mid_ok = (dp <= per_a);
    assign mid    = {1'b0, dp} + (({1'b0, per_a} + (CW+1)'(1) - {1'b0, dp}) >> 1);

    assign adc_trig[g] = run & en_p & mid_ok & ({1'b0, sc} == mid);
    assign gate_hi[g]  = pq & (dc >= dead) & en_p & ~ns_p & ~flt;
    assign gate_lo[g]  = ~pq & (dc >= dead) & en_p & ~flt;

    a_r2_one_shot_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (run && sc == per_a && !trig) |=> !run);
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi[g] && gate_lo[g]));
    a_r5_trig_in_off: assert property (@(posedge clk) disable iff (!rst_n)
      adc_trig[g] |-> !raw);
    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en_p |-> (!gate_hi[g] && !gate_lo[g] && !adc_trig[g]));
    a_r7_low_side_only: assert property (@(posedge clk) disable iff (!rst_n)
      ns_p |-> !gate_hi[g]);
  end
endmodule

// File: tb/ilv_pwm_bench.sv
`timescale 1ns/1ps
module ilv_pwm_bench;
  localparam int NPH = 6, CW = 16, DTW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] period = '0;
  logic [NPH*CW-1:0] duty = '0;
  logic [DTW-1:0] dead = '0;
  logic [NPH-1:0] phase_en = '0, nonsync = '0;
  logic fault_in = 1'b0, fault_clr = 1'b0;
  logic [NPH-1:0] gate_hi, gate_lo, adc_trig;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ilv_pwm #(.NPH(NPH), .CW(CW), .DTW(DTW)) u_ilv_pwm (
    .clk(clk), .rst_n(rst_n), .period(period), .duty(duty), .dead(dead),
    .phase_en(phase_en), .nonsync(nonsync), .fault_in(fault_in), .fault_clr(fault_clr),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .adc_trig(adc_trig));

  // cycle model built from the requirements
  int mc, per, sc[NPH], dA[NPH], dP[NPH], dc[NPH];
  bit run[NPH], enA[NPH], enP[NPH], nsA[NPH], nsP[NPH], pq[NPH], flt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc <= 0; per <= 0; flt <= 0;
      for (int i = 0; i < NPH; i++) begin
        sc[i] <= 0; dA[i] <= 0; dP[i] <= 0; dc[i] <= 0;
        run[i] <= 0; enA[i] <= 0; enP[i] <= 0; nsA[i] <= 0; nsP[i] <= 0; pq[i] <= 0;
      end
    end else begin
      for (int i = 0; i < NPH; i++) begin
        bit r;
        r = run[i] && enP[i] && (sc[i] < dP[i]);
        if (mc == ((per + 1) * i) / NPH) begin
          sc[i] <= 0; run[i] <= 1; dP[i] <= dA[i]; enP[i] <= enA[i]; nsP[i] <= nsA[i];
        end else if (run[i]) begin
          if (sc[i] == per) run[i] <= 0; else sc[i] <= sc[i] + 1;
        end
        pq[i] <= r;
        dc[i] <= (r != pq[i]) ? 0 : (dc[i] < 255 ? dc[i] + 1 : dc[i]);
      end
      if (mc == per) begin
        mc <= 0; per <= int'(period);
        for (int i = 0; i < NPH; i++) begin
          dA[i] <= int'(duty[i*CW +: CW]); enA[i] <= phase_en[i]; nsA[i] <= nonsync[i];
        end
      end else mc <= mc + 1;
      if (fault_in) flt <= 1; else if (fault_clr) flt <= 0;
    end
  end

  function automatic bit exp_hi(int i);
    return !(flt || fault_in) && enP[i] && !nsP[i] && pq[i] && dc[i] >= int'(dead);
  endfunction
  function automatic bit exp_lo(int i);
    return !(flt || fault_in) && enP[i] && !pq[i] && dc[i] >= int'(dead);
  endfunction
  function automatic bit exp_adc(int i);
    return run[i] && enP[i] && dP[i] <= per && sc[i] == dP[i] + (per + 1 - dP[i]) / 2;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    logic [NPH-1:0] eh, el, ea;
    @(negedge clk);
    cyc++;
    for (int i = 0; i < NPH; i++) begin
      eh[i] = exp_hi(i); el[i] = exp_lo(i); ea[i] = exp_adc(i);
    end
    chk("R4 gate_hi vs model", int'(gate_hi), int'(eh));
    chk("R4 gate_lo vs model", int'(gate_lo), int'(el));
    chk("R5 adc_trig vs model", int'(adc_trig), int'(ea));
  endtask

  task automatic run_n(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int t0a, t0b, t1, hon, lon, act5, hi1, lo1;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R10 gates in reset", int'({gate_hi, gate_lo, adc_trig}), 0);
    rst_n = 1'b1;

    // directed: P=29, duty 10, gap 2
    period = 16'd29; dead = 8'd2; phase_en = '1; nonsync = '0;
    for (int i = 0; i < NPH; i++) duty[i*CW +: CW] = 16'd10;
    run_n(70);
    t0a = -1; t0b = -1; t1 = -1; hon = 0; lon = 0;
    for (int k = 0; k < 60; k++) begin
      step();
      if (adc_trig[0]) begin if (t0a < 0) t0a = k; else if (t0b < 0) t0b = k; end
      if (adc_trig[1] && t1 < 0) t1 = k;
      if (k < 30) begin hon += int'(gate_hi[0]); lon += int'(gate_lo[0]); end
    end
    chk("R1 trigger spacing equals P+1", t0b - t0a, 30);
    chk("R2 leg1 offset from leg0", (t1 - t0a + 30) % 30, 5);
    chk("R3 high-side on-time per period", hon, 8);
    chk("R4 low-side on-time per period", lon, 18);

    // directed: leg5 masked, leg1 low-side only
    phase_en = 6'b011111; nonsync = 6'b000010;
    run_n(70);
    act5 = 0; hi1 = 0; lo1 = 0;
    for (int k = 0; k < 60; k++) begin
      step();
      act5 += int'(gate_hi[5]) + int'(gate_lo[5]) + int'(adc_trig[5]);
      hi1 += int'(gate_hi[1]); lo1 += int'(gate_lo[1]);
    end
    chk("R6 masked leg activity", act5, 0);
    chk("R7 low-side-only high drive", hi1, 0);
    chk("R7 low-side-only low drive switching", int'(lo1 > 0), 1);

    // directed: fault
    run_n(7);
    fault_in = 1'b1;
    #1;
    checks++;
    chk("R8 immediate blanking", int'({gate_hi, gate_lo}), 0);
    run_n(3);
    fault_in = 1'b0;
    run_n(40);
    chk("R9 blanking held after fault drops", int'({gate_hi, gate_lo}), 0);
    fault_clr = 1'b1; step(); fault_clr = 1'b0;
    run_n(60);
    chk("R9 gates resume after clear", int'(|{gate_hi, gate_lo}), 1);

    // directed: duty beyond period -> no trigger, stays on
    period = 16'd11; phase_en = '1; nonsync = '0;
    for (int i = 0; i < NPH; i++) duty[i*CW +: CW] = 16'd14;
    run_n(50);
    act5 = 0;
    for (int k = 0; k < 24; k++) begin step(); act5 += int'(|adc_trig); end
    chk("R5 no trigger when duty exceeds period", act5, 0);

    // random segments
    for (int s = 0; s < 14; s++) begin
      period = CW'(6 + $urandom % 40);
      for (int i = 0; i < NPH; i++) duty[i*CW +: CW] = CW'($urandom % (int'(period) + 3));
      dead = DTW'($urandom % 5);
      phase_en = NPH'($urandom);
      nonsync = NPH'($urandom & $urandom);
      run_n(150);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule